// File: doc/BRIEF.md
# Sinc Decimation Filter with Settling Control

This block turns a 1-bit oversampled stream into multi-bit words at a lower rate. Each accepted input sample counts as 1 when the bit is high and 0 when it is low. The filter has two responses. The normal response is a third-order sinc, built from a cascaded integrator-comb chain. The fast response is a first-order sinc, which is a plain count of ones over one decimation window. The decimation ratio R is a power of two, chosen by a select field and a clock-range bit.

The block asserts its output flag only when the word it presents is fully settled. After reset, after any change to the ratio or the filter order, and after the hold input is released, the datapath starts from zero and withholds early words. It withholds two words in third-order mode and none in fast mode. While hold is high, the datapath stays in reset and no conversions occur. The flag and the last word are kept during hold, and a read can still clear the flag.

The input side is a valid-only stream. The block always accepts a sample, so there is no back-pressure toward the modulator. The output side is a valid/ready pair. `out_valid` rises with each settled word and stays high until a cycle with `out_ready` high consumes it. The filter is self-timed and cannot stall. If a word is not read, the next settled word overwrites it and `out_valid` stays high.

Top module: `sinc_decimator`

## Requirements
- R1: The decimation ratio is R = 2^(4 + osr_sel + rate_hi), with osr_sel read as an unsigned value. The block produces one filter result per R accepted samples.
- R2: In third-order mode (fast_en=0), an input whose pattern period divides R gives a settled word equal to R*R*K, where K is the number of ones in any R consecutive samples.
- R3: In fast mode (fast_en=1), a settled word equals the number of ones among the R samples of its window.
- R4: After a restart, third-order mode withholds the first two results and presents the third. Fast mode presents the first result.
- R5: Any change of osr_sel, rate_hi or fast_en drops out_valid on the next clock edge and restarts settling. Switching from fast mode to third-order mode therefore presents no word until the third new result.
- R6: While hold is high, no word is produced, out_valid is not cleared by hold, and out_data keeps its value.
- R7: A cycle with out_ready high and out_valid high clears out_valid. This also applies while hold is high.
- R8: After hold falls, the sample count starts from zero and the full settling rule of R4 applies.
- R9: After reset, out_valid is 0 and out_data is 0.
- R10: Cycles with in_valid low have no effect, whatever the value of in_bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_bit as one modulator sample |
| in_bit | input | 1 | Modulator output bit |
| osr_sel | input | 2 | Ratio select (exponent offset) |
| rate_hi | input | 1 | Clock-range bit, doubles the ratio |
| fast_en | input | 1 | 1 selects the first-order response |
| hold | input | 1 | Holds the datapath in reset |
| out_ready | input | 1 | Consumes the presented word |
| out_data | output | 25 | Settled filter result |
| out_valid | output | 1 | A settled word is waiting |

## Verification
The bench targets the settling edges. If a design presents words one decimation too early after a restart, the scoreboard receives a word it did not expect: a partial sum, which is too small. The bench also switches from fast mode to third-order mode with an unread word pending. A design that ignores the change would keep out_valid high, or would emit a word before the third new result. In the hold test, the bench feeds zeros while hold is high. A design that kept converting would replace the held word with 0, and a design that cleared the flag on hold would drop out_valid. The bench also inserts idle gaps with in_bit high and checks R=256 in third-order mode. These catch designs that count unqualified bits or overflow the widest sum.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  // Filter configuration that, when altered, forces a restart.
  typedef struct packed {
    logic [1:0] osr_sel;
    logic       rate_hi;
    logic       fast_en;
  } sinc_cfg_t;
endpackage

// File: rtl/sinc_integrator.sv
module sinc_integrator #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc
);
  // Wrap-around accumulation; comb differences recover the exact sum.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + din;
  end
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] dly;

  assign dout = din - dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dly <= '0;
    else if (clr) dly <= '0;
    else if (en)  dly <= din;
  end
endmodule

// File: rtl/sinc_settle_ctrl.sv
module sinc_settle_ctrl #(
  parameter int ORDER = 3,
  localparam int SW = $clog2(ORDER + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_chg,
  input  logic hold,
  input  logic fast_en,
  input  logic dec_tick,
  input  logic rd,
  output logic publish,
  output logic ready
);
  logic          restart;
  logic [SW-1:0] seen;
  logic [SW-1:0] need;

  assign restart = cfg_chg | hold;
  assign need    = fast_en ? SW'(1) : SW'(ORDER);
  assign publish = dec_tick && !restart &&
                   (({1'b0, seen} + (SW+1)'(1)) >= {1'b0, need});

  // Results seen since the last restart, saturating at ORDER.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                seen <= '0;
    else if (restart)                          seen <= '0;
    else if (dec_tick && seen != SW'(ORDER))   seen <= seen + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ready <= 1'b0;
    else if (cfg_chg) ready <= 1'b0;
    else if (publish) ready <= 1'b1;
    else if (rd)      ready <= 1'b0;
  end

  // R5
  cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !ready);

  // R6
  hold_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && ready && !rd && !cfg_chg) |=> ready);
endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_pkg::*;
#(
  parameter int BASE_LOG2 = 4,
  parameter int SEL_W     = 2,
  parameter int ORDER     = 3,
  localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W),
  localparam int ACC_W    = ORDER * MAX_LOG2 + 1,
  localparam int CNT_W    = MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic [SEL_W-1:0] osr_sel,
  input  logic             rate_hi,
  input  logic             fast_en,
  input  logic             hold,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  output logic             out_valid
);
  sinc_cfg_t   cfg_now, cfg_q;
  logic        cfg_chg, restart;
  int unsigned log2r;
  logic [CNT_W-1:0] ratio_last, phase;
  logic        dec_q, publish;

  assign cfg_now = '{osr_sel: 2'(osr_sel), rate_hi: rate_hi, fast_en: fast_en};
  assign cfg_chg = (cfg_now != cfg_q);
  assign restart = cfg_chg | hold;

  always_comb begin
    log2r      = 32'(BASE_LOG2) + 32'(osr_sel) + 32'(rate_hi);
    ratio_last = CNT_W'((33'd1 << log2r) - 33'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      phase <= '0;
      dec_q <= 1'b0;
    end else begin
      cfg_q <= cfg_now;
      dec_q <= !restart && in_valid && (phase == ratio_last);
      if (restart)       phase <= '0;
      else if (in_valid) phase <= (phase == ratio_last) ? '0 : phase + CNT_W'(1);
    end
  end

  // Integrator cascade at the sample rate.
  logic [ORDER:0][ACC_W-1:0] integ;
  assign integ[0] = {{(ACC_W-1){1'b0}}, in_bit};
  for (genvar k = 0; k < ORDER; k++) begin : g_int
    sinc_integrator #(.W(ACC_W)) u_int (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .clr(restart),
      .din(integ[k]), .acc(integ[k+1])
    );
  end

  // Comb cascade at the output rate.
  logic [ORDER:0][ACC_W-1:0] cmb;
  assign cmb[0] = integ[ORDER];
  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    sinc_comb #(.W(ACC_W)) u_comb (
      .clk(clk), .rst_n(rst_n), .en(dec_q), .clr(restart),
      .din(cmb[k]), .dout(cmb[k+1])
    );
  end

  // First-order path: one comb on the first integrator.
  logic [ACC_W-1:0] fast_val;
  sinc_comb #(.W(ACC_W)) u_fast (
    .clk(clk), .rst_n(rst_n), .en(dec_q), .clr(restart),
    .din(integ[1]), .dout(fast_val)
  );

  sinc_settle_ctrl #(.ORDER(ORDER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_chg(cfg_chg), .hold(hold),
    .fast_en(fast_en), .dec_tick(dec_q), .rd(out_ready),
    .publish(publish), .ready(out_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_data <= '0;
    else if (publish) out_data <= fast_en ? fast_val : cmb[ORDER];
  end

  // R1
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> (phase <= ratio_last));

  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(out_data));

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(dec_q));
endmodule

// File: tb/sinc_decimator_test.sv
module sinc_decimator_test;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_bit = 0;
  logic [1:0]  osr_sel = 0;
  logic        rate_hi = 0, fast_en = 0, hold = 0;
  logic        mon_rd = 0, man_rd = 0, mon_en = 0;
  logic [24:0] out_data;
  logic        out_valid;
  int checks = 0, errors = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sinc_decimator uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .osr_sel(osr_sel), .rate_hi(rate_hi), .fast_en(fast_en), .hold(hold),
    .out_ready(mon_rd | man_rd), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(int val, int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(val);
      tag_q.push_back(tag);
    end
  endtask

  task automatic set_cfg(logic [1:0] s, logic h, logic f);
    @(posedge clk); #1;
    osr_sel = s; rate_hi = h; fast_en = f;
    repeat (2) @(posedge clk);
  endtask

  task automatic feed(int n, logic [15:0] pat, int plen, int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_bit = pat[i % plen];
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        in_valid = 0; in_bit = 1;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; in_bit = 0;
  endtask

  task automatic drain(string tag);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  // Monitor: pops the scoreboard on each presented word and consumes it.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_rd) mon_rd = 0;
      else if (mon_en && out_valid) begin
        int e; string t;
        if (exp_q.size() == 0) chk(0, "R4 unexpected word", int'(out_data), -1);
        else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(int'(out_data) == e, t, int'(out_data), e);
        end
        mon_rd = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R9 valid", out_valid, 0);
    chk(out_data == 0, "R9 data", int'(out_data), 0);
    #1 rst_n = 1;
    mon_en = 1;

    // R2/R4: R=16 all ones, five results, first two withheld
    set_cfg(0, 0, 0);
    feed(32, 16'h1, 1, 0);
    drain("R4 early");
    push_exp(4096, 3, "R2 ones R=16");
    feed(48, 16'h1, 1, 0);
    drain("R2 count");

    // R2: R=32 alternating pattern
    set_cfg(1, 0, 0);
    push_exp(32*32*16, 2, "R2 alternating R=32");
    feed(128, 16'h2, 2, 0);
    drain("R2 alt count");

    // R3: fast, R=32, period-4 pattern 1100
    set_cfg(1, 0, 1);
    push_exp(16, 3, "R3 fast R=32");
    feed(96, 16'h3, 4, 0);
    drain("R3 count");

    // R10: fast, R=16, gaps with in_bit high
    set_cfg(0, 0, 1);
    push_exp(4, 2, "R10 gaps");
    feed(32, 16'h1, 4, 2);
    drain("R10 count");

    // R1: ratio extremes
    set_cfg(2, 0, 1);
    push_exp(64, 1, "R1 R=64 fast");
    feed(64, 16'h1, 1, 0);
    drain("R1 count64");
    set_cfg(3, 1, 1);
    push_exp(256, 1, "R1 R=256 fast");
    feed(256, 16'h1, 1, 0);
    drain("R1 count256");
    set_cfg(3, 1, 0);
    push_exp(16777216, 1, "R1 R=256 third-order");
    feed(768, 16'h1, 1, 0);
    drain("R1 count768");

    // R5: fast -> third-order with an unread word pending
    mon_en = 0;
    set_cfg(0, 0, 1);
    feed(16, 16'h1, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1, "R3 pending valid", out_valid, 1);
    chk(out_data == 16, "R3 pending data", int'(out_data), 16);
    @(posedge clk); #1 fast_en = 0;
    @(posedge clk); #1;
    chk(out_valid == 0, "R5 drop", out_valid, 0);
    mon_en = 1;
    feed(32, 16'h1, 1, 0);
    drain("R5 early");
    push_exp(4096, 1, "R5 resettled");
    feed(16, 16'h1, 1, 0);
    drain("R5 count");

    // R6/R7/R8: hold behaviour
    mon_en = 0;
    set_cfg(1, 0, 0);
    set_cfg(0, 0, 0);
    feed(48, 16'h1, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1 && out_data == 4096, "R4 word before hold", int'(out_data), 4096);
    @(posedge clk); #1 hold = 1;
    feed(32, 16'h0, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1, "R6 flag kept", out_valid, 1);
    chk(out_data == 4096, "R6 data kept", int'(out_data), 4096);
    @(posedge clk); #1 man_rd = 1;
    @(posedge clk); #1 man_rd = 0;
    chk(out_valid == 0, "R7 read in hold", out_valid, 0);
    hold = 0;
    mon_en = 1;
    feed(32, 16'h0, 1, 0);
    drain("R8 early");
    push_exp(0, 1, "R8 after release");
    feed(16, 16'h0, 1, 0);
    drain("R8 count");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule